// File: doc/BRIEF.md
# Audio FIFO Underflow Status Logic

This block holds the status and error flags of a serial audio port that buffers samples in a FIFO. It watches the FIFO occupancy and the traffic on the data register. When an underflow or an overflow happens, it sets a sticky flag. It raises an interrupt request when a flag and its enable are both 1. Software clears a flag by writing 0 to its status bit. Writing 1 to that bit does nothing.

The direction input picks how an underflow is detected. In receive mode (`tx_mode` = 0), an underflow is a read of the data register while the FIFO is empty. In transmit mode (`tx_mode` = 1), an underflow is a serializer request for a sample that arrives while no new data is waiting. In that case the block keeps the transmit sample valid: it sends the held sample again on every request until new data arrives. A receive read of an empty FIFO returns the previously read value and does not pop the FIFO. The serializer and the FIFO storage sit outside the block. The block only tells the FIFO when to pop, and it registers the serializer's channel, word and idle indications into the status word.

Top module: `audio_fifo_status`

## Requirements
- R1: After reset, `status` reads 0x0200_0003: underflow flag (bit 27) = 0, overflow flag (bit 26) = 0, idle flag (bit 25) = 1, channel number (bits 3:2) = 00, word number (bit 1) = 1, idle state (bit 0) = 1. `irq`, `ser_sample` and `rd_data` are 0.
- R2: In receive mode, a cycle with `rd_strobe` = 1 and `fifo_count` = 0 sets the underflow flag (bit 27) on the next clock edge.
- R3: In transmit mode, a cycle with `ser_req` = 1 and `fifo_count` = 0 sets the underflow flag. A `rd_strobe` in transmit mode never sets it.
- R4: A flag is set on its event whatever the values of `uflow_ie` and `oflow_ie`.
- R5: A cycle with `reg_wr` = 1 clears the underflow flag when `reg_wdata[27]` = 0 and clears the overflow flag when `reg_wdata[26]` = 0. A 1 written to either bit leaves that flag unchanged.
- R6: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up 1.
- R7: `irq` = (underflow flag AND `uflow_ie`) OR (overflow flag AND `oflow_ie`), with no extra cycle of delay.
- R8: The overflow flag (bit 26) is set by `wr_strobe` in transmit mode, or by `rx_push` in receive mode, while `fifo_count` = DEPTH. The same strobes with a smaller count leave it at 0.
- R9: In transmit mode, `ser_req` with `fifo_count` > 0 asserts `tx_pop` in the same cycle and loads `fifo_head` into `ser_sample` on the next edge. With `fifo_count` = 0, `tx_pop` stays 0 and `ser_sample` repeats the held value on every such request.
- R10: In receive mode, `rd_strobe` with `fifo_count` > 0 asserts `rx_pop` in the same cycle and loads `fifo_head` into `rd_data`. With `fifo_count` = 0, `rx_pop` stays 0 and `rd_data` keeps its last value.
- R11: Status bits 3:2, 1, 0 and 25 show `ser_chan`, `ser_word`, `ser_idle` and `ser_idle` one cycle after they are applied. Bits 31:28 and 24:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| fifo_count | input | CNT_W | Number of samples currently in the FIFO |
| fifo_head | input | SAMPLE_W | Sample at the FIFO head |
| rd_strobe | input | 1 | Data register read (receive side) |
| wr_strobe | input | 1 | Data register write (transmit side) |
| rx_push | input | 1 | Received sample arriving at the FIFO |
| ser_req | input | 1 | Serializer requests the next transmit sample |
| ser_chan | input | 2 | Current channel number from the serializer |
| ser_word | input | 1 | Current word number from the serializer |
| ser_idle | input | 1 | Serializer idle indication |
| uflow_ie | input | 1 | Underflow interrupt enable |
| oflow_ie | input | 1 | Overflow interrupt enable |
| reg_wr | input | 1 | Register bus write to the status word |
| reg_wdata | input | 32 | Register bus write data |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| tx_pop | output | 1 | Pop the FIFO for the serializer |
| rx_pop | output | 1 | Pop the FIFO for a data register read |
| ser_sample | output | SAMPLE_W | Sample handed to the serializer |
| rd_data | output | SAMPLE_W | Value returned by a data register read |

## Verification
The in-line assertions check several rules on every cycle. A set event always leaves its flag at 1, even against a clear in the same cycle. A 0 write with no event clears the flag, and a flag with neither event nor clear holds its value. A request or read against an empty FIFO never changes the held sample, and every pop loads the head value. Other behaviour depends on the mode and count combinations and only the bench's scenarios can show it. That includes the reset image of the status word, the difference between the two underflow detections, and a transmit read that must not count as an underflow. It also includes overflow at exactly DEPTH against one below it, the repeated transmit sample across several starved requests, and the interrupt following the enables in the same cycle.

// File: rtl/afs_pkg.sv
package afs_pkg;
   localparam int STAT_UFLAG = 27;
   localparam int STAT_OFLAG = 26;
   localparam int STAT_IFLAG = 25;

   typedef struct packed {
      logic [1:0] chan;
      logic       word;
      logic       idle;
   } ser_state_t;

   localparam ser_state_t SER_RESET = '{chan: 2'b00, word: 1'b1, idle: 1'b1};

   function automatic logic [31:0] pack_status(input logic uf, input logic of,
                                               input ser_state_t s);
      logic [31:0] w;
      w = '0;
      w[STAT_UFLAG] = uf;
      w[STAT_OFLAG] = of;
      w[STAT_IFLAG] = s.idle;
      w[3:2]        = s.chan;
      w[1]          = s.word;
      w[0]          = s.idle;
      return w;
   endfunction
endpackage

// File: rtl/afs_event_detect.sv
module afs_event_detect #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             tx_mode_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             rd_i,
   input  logic             req_i,
   input  logic             wr_i,
   input  logic             push_i,
   output logic             empty_o,
   output logic             under_o,
   output logic             over_o
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic full;

   assign empty_o = (count_i == '0);
   assign full    = (count_i >= FULL_CNT);

   // direction decides which strobe counts as starving the FIFO
   assign under_o = tx_mode_i ? (req_i & empty_o) : (rd_i & empty_o);
   assign over_o  = tx_mode_i ? (wr_i & full)     : (push_i & full);
endmodule

// File: rtl/afs_sticky_flag.sv
module afs_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic clr;
   assign clr = wr_i & ~wbit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr)   flag_o <= 1'b0;
   end

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && wr_i && !wbit_i) |=> flag_o);
   assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wbit_i && !set_i) |=> !flag_o);
   assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !set_i && !(wr_i && !wbit_i)) |=> flag_o);
endmodule

// File: rtl/afs_hold_reg.sv
module afs_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take_i,
   input  logic         empty_i,
   input  logic [W-1:0] head_i,
   output logic         pop_o,
   output logic [W-1:0] data_o
);
   assign pop_o = take_i & ~empty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_o <= '0;
      else if (pop_o) data_o <= head_i;
   end

   // starved request repeats the held value (R9 transmit, R10 receive)
   assert_hold_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && empty_i) |=> $stable(data_o));
   assert_load_on_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !empty_i) |=> (data_o == $past(head_i)));
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
   import afs_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 8,
   parameter int CNT_W    = $clog2(DEPTH + 1),
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_mode,
   input  logic [CNT_W-1:0]    fifo_count,
   input  logic [SAMPLE_W-1:0] fifo_head,
   input  logic                rd_strobe,
   input  logic                wr_strobe,
   input  logic                rx_push,
   input  logic                ser_req,
   input  logic [1:0]          ser_chan,
   input  logic                ser_word,
   input  logic                ser_idle,
   input  logic                uflow_ie,
   input  logic                oflow_ie,
   input  logic                reg_wr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         status,
   output logic                irq,
   output logic                tx_pop,
   output logic                rx_pop,
   output logic [SAMPLE_W-1:0] ser_sample,
   output logic [SAMPLE_W-1:0] rd_data
);
   generate
      if (DEPTH < 1)               begin : g_bad_depth $error("DEPTH must be at least 1"); end
      if (CNT_W < $clog2(DEPTH+1)) begin : g_bad_cnt   $error("CNT_W too narrow for DEPTH"); end
      if (SAMPLE_W < 1)            begin : g_bad_w     $error("SAMPLE_W must be positive"); end
   endgenerate

   logic       empty, under_ev, over_ev;
   logic       uflag, oflag;
   ser_state_t ser_q;
   logic       unused_wdata;

   assign unused_wdata = ^{reg_wdata[31:28], reg_wdata[25:0]};

   afs_event_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_det (
      .tx_mode_i (tx_mode),
      .count_i   (fifo_count),
      .rd_i      (rd_strobe),
      .req_i     (ser_req),
      .wr_i      (wr_strobe),
      .push_i    (rx_push),
      .empty_o   (empty),
      .under_o   (under_ev),
      .over_o    (over_ev)
   );

   afs_sticky_flag u_uflag (
      .clk(clk), .rst_n(rst_n), .set_i(under_ev),
      .wr_i(reg_wr), .wbit_i(reg_wdata[STAT_UFLAG]), .flag_o(uflag)
   );

   afs_sticky_flag u_oflag (
      .clk(clk), .rst_n(rst_n), .set_i(over_ev),
      .wr_i(reg_wr), .wbit_i(reg_wdata[STAT_OFLAG]), .flag_o(oflag)
   );

   afs_hold_reg #(.W(SAMPLE_W)) u_tx_hold (
      .clk(clk), .rst_n(rst_n), .take_i(tx_mode & ser_req),
      .empty_i(empty), .head_i(fifo_head), .pop_o(tx_pop), .data_o(ser_sample)
   );

   afs_hold_reg #(.W(SAMPLE_W)) u_rx_hold (
      .clk(clk), .rst_n(rst_n), .take_i(~tx_mode & rd_strobe),
      .empty_i(empty), .head_i(fifo_head), .pop_o(rx_pop), .data_o(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_q <= SER_RESET;
      else        ser_q <= '{chan: ser_chan, word: ser_word, idle: ser_idle};
   end

   assign status = pack_status(uflag, oflag, ser_q);

   logic irq_now;
   assign irq_now = (uflag & uflow_ie) | (oflag & oflow_ie);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_now;
         end
      end else begin : g_irq_comb
         assign irq = irq_now;
      end
   endgenerate

   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[31:28] == 4'b0) && (status[24:4] == 21'b0));
   assert_tx_read_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode && rd_strobe && !ser_req && !uflag) |=> !uflag);
endmodule

// File: tb/sim_audio_fifo_status.sv
`timescale 1ns/100ps
module sim_audio_fifo_status;
   localparam int SW = 16, DEPTH = 8, CW = 4;

   logic clk = 0, rst_n = 0;
   logic tx_mode = 0, rd_strobe = 0, wr_strobe = 0, rx_push = 0, ser_req = 0;
   logic [CW-1:0] fifo_count = 0;
   logic [SW-1:0] fifo_head = 0;
   logic [1:0] ser_chan = 0;
   logic ser_word = 1, ser_idle = 1, uflow_ie = 0, oflow_ie = 0, reg_wr = 0;
   logic [31:0] reg_wdata = 0, status;
   logic irq, tx_pop, rx_pop;
   logic [SW-1:0] ser_sample, rd_data;

   always #2 clk = ~clk;

   audio_fifo_status #(.SAMPLE_W(SW), .DEPTH(DEPTH), .CNT_W(CW)) u0 (.*);

   typedef struct { string tag; int sel; logic [31:0] exp; } item_t;
   item_t sb[$];
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic logic [31:0] st(logic u, logic o, logic [1:0] c, logic w, logic i);
      return {4'b0, u, o, i, 21'b0, c, w, i};
   endfunction

   task automatic expect_v(string tag, int sel, logic [31:0] e);
      item_t it; it.tag = tag; it.sel = sel; it.exp = e;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   // monitor: 0 status 1 irq 2 ser_sample 3 rd_data 4 tx_pop 5 rx_pop
   initial forever begin
      item_t it; logic [31:0] act;
      wait (sb.size() > 0);
      it = sb.pop_front();
      case (it.sel)
         0: act = status;
         1: act = {31'b0, irq};
         2: act = {16'b0, ser_sample};
         3: act = {16'b0, rd_data};
         4: act = {31'b0, tx_pop};
         default: act = {31'b0, rx_pop};
      endcase
      checks++;
      if (act !== it.exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
   end

   task automatic clear_strobes();
      rd_strobe = 0; wr_strobe = 0; rx_push = 0; ser_req = 0; reg_wr = 0;
   endtask

   // drive at negedge, settle, then step to just after the next edge
   task automatic drive_edge();
      @(posedge clk); #1; clear_strobes();
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #9 rst_n = 1;
      @(negedge clk);
      expect_v("R1 status", 0, 32'h0200_0003);
      expect_v("R1 irq", 1, 0);
      expect_v("R1 ser_sample", 2, 0);
      expect_v("R1 rd_data", 3, 0);

      // R11 serializer state
      @(negedge clk); ser_chan = 2'b10; ser_word = 0; ser_idle = 0;
      drive_edge();
      expect_v("R11 state", 0, st(0, 0, 2'b10, 0, 0));
      @(negedge clk); ser_chan = 2'b01; ser_word = 1; ser_idle = 1;
      drive_edge();
      expect_v("R11 state2", 0, st(0, 0, 2'b01, 1, 1));

      // R10 receive read with data
      @(negedge clk); fifo_count = 3; fifo_head = 16'h1234; rd_strobe = 1; #1;
      expect_v("R10 rx_pop", 5, 1);
      drive_edge();
      expect_v("R10 rd_data", 3, 16'h1234);
      expect_v("R2 no flag", 0, st(0, 0, 2'b01, 1, 1));

      // R2 receive underflow, R4 with enable off
      @(negedge clk); fifo_count = 0; fifo_head = 16'hBEEF; rd_strobe = 1; #1;
      expect_v("R10 no pop", 5, 0);
      drive_edge();
      expect_v("R10 rd_data held", 3, 16'h1234);
      expect_v("R2 uflag", 0, st(1, 0, 2'b01, 1, 1));
      expect_v("R4 irq off", 1, 0);
      @(negedge clk); uflow_ie = 1; #1;
      expect_v("R7 irq on", 1, 1);

      // R5 write 1 ignored, write 0 clears
      @(negedge clk); reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
      drive_edge();
      expect_v("R5 write1 keeps", 0, st(1, 0, 2'b01, 1, 1));
      @(negedge clk); reg_wr = 1; reg_wdata = 32'h0;
      drive_edge();
      expect_v("R5 write0 clears", 0, st(0, 0, 2'b01, 1, 1));
      expect_v("R7 irq cleared", 1, 0);

      // R9 transmit with data, then starved repeats
      @(negedge clk); tx_mode = 1; fifo_count = 2; fifo_head = 16'hA5A5; ser_req = 1; #1;
      expect_v("R9 tx_pop", 4, 1);
      drive_edge();
      expect_v("R9 sample", 2, 16'hA5A5);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); fifo_count = 0; fifo_head = 16'h5A5A + 16'(k); ser_req = 1; #1;
         expect_v("R9 no pop", 4, 0);
         drive_edge();
         expect_v("R9 repeat", 2, 16'hA5A5);
         expect_v("R3 uflag", 0, st(1, 0, 2'b01, 1, 1));
      end
      @(negedge clk); reg_wr = 1; reg_wdata = 32'h0;
      drive_edge();
      // R3 a read in transmit mode is not an underflow
      @(negedge clk); fifo_count = 0; rd_strobe = 1; #1;
      expect_v("R10 tx read no pop", 5, 0);
      drive_edge();
      expect_v("R3 tx read no flag", 0, st(0, 0, 2'b01, 1, 1));

      // R6 set beats clear
      @(negedge clk); ser_req = 1; reg_wr = 1; reg_wdata = 32'h0;
      drive_edge();
      expect_v("R6 set wins", 0, st(1, 0, 2'b01, 1, 1));
      @(negedge clk); reg_wr = 1; reg_wdata = 32'h0;
      drive_edge();

      // R8 overflow boundaries
      @(negedge clk); fifo_count = DEPTH - 1; wr_strobe = 1;
      drive_edge();
      expect_v("R8 below full", 0, st(0, 0, 2'b01, 1, 1));
      @(negedge clk); fifo_count = DEPTH; wr_strobe = 1;
      drive_edge();
      expect_v("R8 tx overflow", 0, st(0, 1, 2'b01, 1, 1));
      expect_v("R7 oflow masked", 1, 0);
      @(negedge clk); oflow_ie = 1; #1;
      expect_v("R7 oflow irq", 1, 1);
      // R5 clear only overflow, keep underflow via bit27 = 1
      @(negedge clk); reg_wr = 1; reg_wdata = 32'h0800_0000;
      drive_edge();
      expect_v("R5 clear oflag only", 0, st(0, 0, 2'b01, 1, 1));
      @(negedge clk); tx_mode = 0; fifo_count = DEPTH; rx_push = 1;
      drive_edge();
      expect_v("R8 rx overflow", 0, st(0, 1, 2'b01, 1, 1));

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule